// File: doc/BRIEF.md
# Edge-Latched Interrupt Status Controller

This block watches six synchronous interrupt source lines. Each line has its own enable bit. A rising edge on an enabled line sets a sticky status bit. No clear register exists, so a status bit returns to zero only when its enable bit is written to zero. While a line is disabled, its status bit is forced to zero and edges on that line are ignored. Edges are found by comparing each line with its value from the previous clock. A line that is already high when it is enabled does not count as an edge.

The request output gives one pulse in the cycle in which the status word changes from all-zero to non-zero. No further pulse is possible until the whole word has gone back to zero.

The whole enable word is written through a write strobe with data. The status word can be read at any time. A sampling port takes a list of up to six 3-bit channel selects and an entry count. It returns the status bits packed into a 16-bit word, one bit per listed channel, in list order.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After a synchronous reset, the status word, the enable word and `irq_pulse` are all 0.
- R2: A source line is high at a clock edge, was low at the previous edge, and its enable bit is 1 after that edge. Its status bit then reads 1 from that edge onward. An enable write taken at the same edge counts.
- R3: A set status bit stays 1 while its enable bit stays 1, whatever its source line does afterwards.
- R4: While a source's enable bit is 0, its status bit reads 0, and rising edges on that source do not set the bit.
- R5: Writing the enable word with a bit at 0 clears the matching status bit at the edge that takes the write. Status bits whose enable stays 1 keep their value.
- R6: A source line that is already high when its enable bit becomes 1 does not set its status bit until the line goes low and then rises again.
- R7: `irq_pulse` is 1 for exactly one cycle: the first cycle in which the status word is non-zero after a cycle in which it was zero.
- R8: While the status word stays non-zero, `irq_pulse` stays 0, even when more status bits become set. Once the word has been zero for a cycle, the next set bit raises a new pulse.
- R9: For each entry i below the entry count, bit i of `samp_word` equals the status bit selected by entry i. Entry i is in bits [3i+2:3i] of `samp_list`.
- R10: Bits of `samp_word` at or above the entry count read 0. An entry count above 6 is treated as 6. A select value of 6 or 7 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 6 | Synchronous interrupt source lines |
| en_we | input | 1 | Write strobe for the enable word |
| en_wdata | input | 6 | New enable word |
| status_rdata | output | 6 | Current sticky status word |
| irq_pulse | output | 1 | One-cycle request on the status word's zero to non-zero change |
| samp_list | input | 18 | Six 3-bit channel selects, entry 0 in the low bits |
| samp_count | input | 3 | Number of valid list entries |
| samp_word | output | 16 | Status bits packed in list order, zero above the count |

## Verification
The bench builds the block with its defaults: six sources, 3-bit selects, a 3-bit count and a 16-bit packed word. With these widths, select codes 6 and 7 and an entry count of 7 can all be driven, so the out-of-range paths of the packer are exercised. The ten packed-word bits above the source count can also be checked for zero. The 6-bit status word is small enough that random enable writes often drive it back to zero, so the pulse re-arms many times during the random phase.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

    localparam int IRQ_SRC_N   = 6;
    localparam int IRQ_PACK_W  = 16;

    // per-source state carried by each edge cell
    typedef struct packed {
        logic prev;
        logic stat;
    } cell_state_t;

    // safe pick of one status bit by a select code; out-of-range codes give 0
    function automatic logic pick_bit(input logic [31:0] word, input int sel, input int n);
        if (sel < n && sel >= 0)
            return word[sel];
        return 1'b0;
    endfunction

    // clamp an entry count to the number of list slots
    function automatic int clamp_count(input int cnt, input int limit);
        return (cnt > limit) ? limit : cnt;
    endfunction

endpackage

// File: rtl/irq_edge_cell.sv
module irq_edge_cell
    import irq_latch_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic src,
    input  logic en_next,
    output logic stat_q
);

    cell_state_t st_q;
    cell_state_t st_d;
    logic        rise;

    always_comb begin
        rise      = src & ~st_q.prev;
        st_d.prev = src;
        st_d.stat = en_next & (st_q.stat | rise);
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign stat_q = st_q.stat;

    p_rise_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (en_next && src && !st_q.prev) |=> stat_q);

    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (stat_q && en_next) |=> stat_q);

    p_disable_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (!en_next) |=> !stat_q);

endmodule

// File: rtl/irq_assert_gen.sv
module irq_assert_gen #(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] status,
    output logic               irq_pulse
);

    logic any_now;
    logic any_prev_q;

    assign any_now = |status;

    always_ff @(posedge clk) begin
        if (rst)
            any_prev_q <= 1'b0;
        else
            any_prev_q <= any_now;
    end

    assign irq_pulse = any_now & ~any_prev_q;

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> !irq_pulse);

    p_pulse_needs_status_r7: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> (status != '0));

    p_no_repeat_r8: assert property (@(posedge clk) disable iff (rst)
        ((status != '0) && $past(status != '0)) |-> !irq_pulse);

endmodule

// File: rtl/irq_pack_sampler.sv
module irq_pack_sampler
    import irq_latch_pkg::*;
#(
    parameter int NUM_SRC = 6,
    parameter int PACK_W  = 16,
    parameter int SEL_W   = 3,
    parameter int CNT_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_SRC-1:0]       status,
    input  logic [NUM_SRC*SEL_W-1:0] list,
    input  logic [CNT_W-1:0]         count,
    output logic [PACK_W-1:0]        word
);

    int          eff_count;
    logic [31:0] status_wide;

    assign eff_count   = clamp_count(int'(count), NUM_SRC);
    assign status_wide = 32'(status);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
        logic [SEL_W-1:0] sel;
        assign sel     = list[i*SEL_W +: SEL_W];
        assign word[i] = (i < eff_count) ? pick_bit(status_wide, int'(sel), NUM_SRC) : 1'b0;
    end

    if (PACK_W > NUM_SRC) begin : g_pad
        assign word[PACK_W-1:NUM_SRC] = '0;
    end

    p_unused_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (word >> eff_count) == '0);

endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
    import irq_latch_pkg::*;
#(
    parameter int NUM_SRC = IRQ_SRC_N,
    parameter int PACK_W  = IRQ_PACK_W,
    localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int CNT_W  = $clog2(NUM_SRC + 1),
    localparam int LIST_W = NUM_SRC * SEL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               en_we,
    input  logic [NUM_SRC-1:0] en_wdata,
    output logic [NUM_SRC-1:0] status_rdata,
    output logic               irq_pulse,
    input  logic [LIST_W-1:0]  samp_list,
    input  logic [CNT_W-1:0]   samp_count,
    output logic [PACK_W-1:0]  samp_word
);

    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] en_next;
    logic [NUM_SRC-1:0] status_q;

    assign en_next = en_we ? en_wdata : en_q;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else
            en_q <= en_next;
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        irq_edge_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .src     (src_in[s]),
            .en_next (en_next[s]),
            .stat_q  (status_q[s])
        );
    end

    irq_assert_gen #(.NUM_SRC(NUM_SRC)) u_gen (
        .clk       (clk),
        .rst       (rst),
        .status    (status_q),
        .irq_pulse (irq_pulse)
    );

    irq_pack_sampler #(
        .NUM_SRC (NUM_SRC),
        .PACK_W  (PACK_W),
        .SEL_W   (SEL_W),
        .CNT_W   (CNT_W)
    ) u_pack (
        .clk    (clk),
        .rst    (rst),
        .status (status_q),
        .list   (samp_list),
        .count  (samp_count),
        .word   (samp_word)
    );

    assign status_rdata = status_q;

    p_off_means_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (status_q & ~en_q) == '0);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (status_q == '0 && !irq_pulse));

endmodule

// File: tb/irq_latch_ctrl_test.sv
module irq_latch_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  src_in = '0;
    logic        en_we = 1'b0;
    logic [5:0]  en_wdata = '0;
    logic [5:0]  status_rdata;
    logic        irq_pulse;
    logic [17:0] samp_list = '0;
    logic [2:0]  samp_count = '0;
    logic [15:0] samp_word;

    int checks = 0;
    int errors = 0;

    logic [5:0] m_en = '0, m_prev = '0, m_st = '0;
    logic       m_anyp = 1'b0, m_irq = 1'b0;

    always #10 clk = ~clk;

    irq_latch_ctrl uut (
        .clk(clk), .rst(rst), .src_in(src_in), .en_we(en_we), .en_wdata(en_wdata),
        .status_rdata(status_rdata), .irq_pulse(irq_pulse),
        .samp_list(samp_list), .samp_count(samp_count), .samp_word(samp_word)
    );

    function automatic logic [15:0] pack_exp(input logic [5:0] st, input logic [17:0] lst, input logic [2:0] cnt);
        logic [15:0] w = '0;
        int n = (int'(cnt) > 6) ? 6 : int'(cnt);
        for (int i = 0; i < n; i++) begin
            int sel = int'(lst[i*3 +: 3]);
            w[i] = (sel < 6) ? st[sel] : 1'b0;
        end
        return w;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input string tag);
        logic [5:0] en_n, rise, st_n;
        logic anyp_n;
        @(posedge clk);
        en_n   = en_we ? en_wdata : m_en;
        rise   = src_in & ~m_prev;
        st_n   = en_n & (m_st | rise);
        anyp_n = |m_st;
        m_irq  = (|st_n) && !anyp_n;
        m_st = st_n; m_en = en_n; m_prev = src_in; m_anyp = anyp_n;
        @(negedge clk);
        chk({tag, " status"}, 16'(status_rdata), 16'(m_st));
        chk({tag, " irq"}, 16'(irq_pulse), 16'(m_irq));
        chk({tag, " pack"}, samp_word, pack_exp(m_st, samp_list, samp_count));
    endtask

    initial begin
        #(20 * 5000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 status", 16'(status_rdata), 16'h0);
        chk("R1 irq", 16'(irq_pulse), 16'h0);
        samp_count = 3'd6;
        samp_list  = {3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};

        // R4: edges while disabled are ignored
        src_in = 6'h3F; tick("R4 rise disabled");
        chk("R4 literal", 16'(status_rdata), 16'h0);
        src_in = 6'h00; tick("R4 fall");
        src_in = 6'h01; tick("R4 src0 high");
        // R6: enable while src0 already high
        en_we = 1'b1; en_wdata = 6'h3F; tick("R6 enable");
        en_we = 1'b0; tick("R6 hold");
        chk("R6 literal", 16'(status_rdata), 16'h0);
        src_in = 6'h00; tick("R6 fall");
        // R2 + R7
        src_in = 6'h01; tick("R2 R7 rise");
        chk("R7 literal irq", 16'(irq_pulse), 16'h1);
        chk("R2 literal", 16'(status_rdata), 16'h01);
        tick("R7 after");
        chk("R7 literal drop", 16'(irq_pulse), 16'h0);
        // R8: more bits, no new pulse; R3 sticky
        src_in = 6'h09; tick("R8 second bit");
        chk("R8 literal", 16'(irq_pulse), 16'h0);
        src_in = 6'h00; tick("R3 fall");
        chk("R3 literal", 16'(status_rdata), 16'h09);
        // R9 and R10 packing
        samp_list = {3'd7, 3'd6, 3'd1, 3'd5, 3'd0, 3'd3}; samp_count = 3'd3;
        tick("R9 order");
        chk("R9 literal", samp_word, 16'h0003);
        samp_count = 3'd7; tick("R10 clamp");
        chk("R10 literal", samp_word, 16'h0003);
        samp_count = 3'd1; tick("R10 count1");
        chk("R10 literal count1", samp_word, 16'h0001);
        // R5 selective clear
        en_we = 1'b1; en_wdata = 6'h3E; tick("R5 clear bit0");
        chk("R5 literal", 16'(status_rdata), 16'h08);
        en_wdata = 6'h00; tick("R5 clear all");
        en_wdata = 6'h3F; tick("R8 reenable");
        en_we = 1'b0;
        src_in = 6'h04; tick("R8 new pulse");
        chk("R8 literal rearm", 16'(irq_pulse), 16'h1);
        // R2 write and rise at the same edge
        en_we = 1'b1; en_wdata = 6'h00; src_in = 6'h00; tick("R2 clear");
        en_wdata = 6'h02; src_in = 6'h02; tick("R2 same edge");
        chk("R2 literal same edge", 16'(status_rdata), 16'h02);
        en_we = 1'b0;

        // random phase
        for (int k = 0; k < 600; k++) begin
            src_in     = 6'($urandom);
            en_we      = ($urandom % 6) == 0;
            en_wdata   = 6'($urandom);
            samp_list  = 18'($urandom);
            samp_count = 3'($urandom);
            tick("R3 R8 R9 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule